// File: doc/BRIEF.md
# Video Blanking and Sync Inserter

This block is the digital stage that feeds a triple 10-bit video DAC (G/Y, B/Cb, R/Cr). Each clock it captures three channel codes, the active-low blank and sync strobes, the sync-polarity control and four configuration flags. From these it produces the three DAC codes, a per-channel sync-current enable, a sync polarity and a DC-bias enable for the R/G/B/Y channels.

Blanking replaces all channel codes with a level that depends on the color space (RGB or YCbCr) and on the code range (full 0..1023 or reduced 64..940/960). Sync overrides blanking, holds the affected channels at their blanking codes and drives the sync enables, either on G/Y alone or on all three channels, with a negative or a positive excursion so that bi-level and tri-level sync can be built. In reduced-range YCbCr the chroma codes are rescaled digitally so that their span equals the luma span. A generic mode turns off sync and bias and uses full-range blanking positions.

Top module: `vsb_top`

## Requirements
- R1: Every input is captured on the rising clock edge; the outputs reflect the values captured on the most recent edge (one edge of latency).
- R2: With blank_n low (and no sync in effect), out_g, out_b and out_r all equal their blanking codes regardless of the data inputs.
- R3: Sync (sync_n low, video mode) takes precedence over blank: sync_en bit 0 is set and every channel stays at its blanking code whatever blank_n and the data carry.
- R4: In RGB (cfg_ycc=0) the blanking code on all three channels is 0 in full range and 64 in reduced range.
- R5: In YCbCr (cfg_ycc=1) the G/Y blanking code is 0 in full range and 64 in reduced range; the B/Cb and R/Cr blanking codes are always 512.
- R6: While sync is in effect, sync_pos equals the captured sync_hi (1 = positive excursion above blanking, 0 = negative below it); outside sync it is 0.
- R7: sync_en bit 0 is G/Y, bit 1 is B/Cb, bit 2 is R/Cr; with cfg_sync_all=0 only bit 0 is set during sync, with cfg_sync_all=1 all three bits are set.
- R8: With cfg_generic=1, sync_n has no effect (sync_en=0, sync_pos=0), bias_en is 0, blanking uses full-range codes even if cfg_reduced=1, and blank_n still blanks; with cfg_generic=0, bias_en is 1.
- R9: In video-mode reduced-range YCbCr, active B/Cb and R/Cr codes become 512 + round((c-512)*876/896), ties rounded away from zero, saturated to 0..1023; G/Y is passed unscaled.
- R10: In every other configuration active codes pass to the outputs unchanged on all three channels.
- R11: After reset the outputs are out_g=out_b=out_r=0, sync_en=0, sync_pos=0, bias_en=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_g | input | 10 | G/Y channel code |
| in_b | input | 10 | B/Cb channel code |
| in_r | input | 10 | R/Cr channel code |
| blank_n | input | 1 | Blank strobe, active low |
| sync_n | input | 1 | Sync strobe, active low |
| sync_hi | input | 1 | Sync polarity: 1 positive, 0 negative |
| cfg_ycc | input | 1 | Color space: 0 RGB, 1 YCbCr |
| cfg_reduced | input | 1 | 1 selects the reduced code range |
| cfg_sync_all | input | 1 | 1 applies sync to all channels |
| cfg_generic | input | 1 | 1 selects generic mode |
| out_g | output | 10 | G/Y DAC code |
| out_b | output | 10 | B/Cb DAC code |
| out_r | output | 10 | R/Cr DAC code |
| sync_en | output | 3 | Per-channel sync current enable |
| sync_pos | output | 1 | Sync excursion polarity |
| bias_en | output | 1 | DC bias enable for R/G/B/Y |

## Verification
The bench builds the block with its default parameters: 10-bit codes, a reduced-range floor of 64, a luma ceiling of 940 and a chroma ceiling of 960. With these the scale ratio is 876/896, so the chroma codes 624 and 400 land exactly on rounding ties and 0 and 1023 probe the ends of the scaled range, while random codes cover the full 10-bit space against every combination of the four flags.

// File: rtl/vsb_pkg.sv
package vsb_pkg;
  localparam int CH_G = 0;
  localparam int CH_B = 1;
  localparam int CH_R = 2;
  localparam int N_CH = 3;

  typedef struct packed {
    logic blank_n;
    logic sync_n;
    logic sync_hi;
    logic ycc;
    logic reduced;
    logic sync_all;
    logic generic;
  } vsb_ctrl_t;
endpackage

// File: rtl/vsb_capture.sv
module vsb_capture
  import vsb_pkg::*;
#(
  parameter int DW = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_CH*DW-1:0]   data_in,
  input  vsb_ctrl_t            ctrl_in,
  output logic [N_CH*DW-1:0]   data_q,
  output vsb_ctrl_t            ctrl_q
);
  localparam vsb_ctrl_t CTRL_RST = '{blank_n: 1'b0, sync_n: 1'b1, sync_hi: 1'b0,
                                     ycc: 1'b0, reduced: 1'b0, sync_all: 1'b0,
                                     generic: 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      ctrl_q <= CTRL_RST;
    end else begin
      data_q <= data_in;
      ctrl_q <= ctrl_in;
    end
  end
endmodule

// File: rtl/vsb_chroma_scale.sv
module vsb_chroma_scale #(
  parameter int DW    = 10,
  parameter int LOW   = 64,
  parameter int TOP_Y = 940,
  parameter int TOP_C = 960
) (
  input  logic [DW-1:0] code_in,
  output logic [DW-1:0] code_out
);
  localparam int MID    = 1 << (DW - 1);
  localparam int MAXC   = (1 << DW) - 1;
  localparam int SPAN_Y = TOP_Y - LOW;
  localparam int SPAN_C = TOP_C - LOW;

  function automatic logic [DW-1:0] rescale(input logic [DW-1:0] c);
    int d, mag, q, r;
    d   = int'(c) - MID;
    mag = (d < 0) ? -d : d;
    q   = (mag * SPAN_Y + SPAN_C / 2) / SPAN_C;
    r   = (d < 0) ? MID - q : MID + q;
    if (r < 0) r = 0;
    if (r > MAXC) r = MAXC;
    return r[DW-1:0];
  endfunction

  assign code_out = rescale(code_in);
endmodule

// File: rtl/vsb_chan_out.sv
module vsb_chan_out #(
  parameter int DW    = 10,
  parameter int LOW   = 64,
  parameter int TOP_Y = 940,
  parameter int TOP_C = 960
) (
  input  logic [DW-1:0] data,
  input  logic [DW-1:0] blank_code,
  input  logic          hold,
  input  logic          scale_en,
  output logic [DW-1:0] code
);
  logic [DW-1:0] scaled;

  vsb_chroma_scale #(.DW(DW), .LOW(LOW), .TOP_Y(TOP_Y), .TOP_C(TOP_C)) u_scale (
    .code_in (data),
    .code_out(scaled)
  );

  always_comb begin
    if (hold)          code = blank_code;
    else if (scale_en) code = scaled;
    else               code = data;
  end
endmodule

// File: rtl/vsb_top.sv
module vsb_top
  import vsb_pkg::*;
#(
  parameter int DW    = 10,
  parameter int LOW   = 64,
  parameter int TOP_Y = 940,
  parameter int TOP_C = 960
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] in_g,
  input  logic [DW-1:0] in_b,
  input  logic [DW-1:0] in_r,
  input  logic          blank_n,
  input  logic          sync_n,
  input  logic          sync_hi,
  input  logic          cfg_ycc,
  input  logic          cfg_reduced,
  input  logic          cfg_sync_all,
  input  logic          cfg_generic,
  output logic [DW-1:0] out_g,
  output logic [DW-1:0] out_b,
  output logic [DW-1:0] out_r,
  output logic [2:0]    sync_en,
  output logic          sync_pos,
  output logic          bias_en
);
  localparam logic [DW-1:0] MID_CODE = DW'(1 << (DW - 1));
  localparam logic [DW-1:0] LOW_CODE = DW'(LOW);

  vsb_ctrl_t            ctrl_in, cq;
  logic [N_CH*DW-1:0]   data_in, data_q, code_all;

  assign data_in = {in_r, in_b, in_g};
  assign ctrl_in = '{blank_n: blank_n, sync_n: sync_n, sync_hi: sync_hi, ycc: cfg_ycc,
                     reduced: cfg_reduced, sync_all: cfg_sync_all, generic: cfg_generic};

  vsb_capture #(.DW(DW)) u_cap (
    .clk    (clk),
    .rst_n  (rst_n),
    .data_in(data_in),
    .ctrl_in(ctrl_in),
    .data_q (data_q),
    .ctrl_q (cq)
  );

  // Named internal events
  logic          video_mode, eff_reduced, sync_act, blank_act, scale_on;
  logic [DW-1:0] y_blank, c_blank;

  assign video_mode  = !cq.generic;
  assign eff_reduced = cq.reduced && video_mode;
  assign sync_act    = !cq.sync_n && video_mode;
  assign blank_act   = !cq.blank_n || sync_act;
  assign scale_on    = eff_reduced && cq.ycc;
  assign y_blank     = eff_reduced ? LOW_CODE : '0;
  assign c_blank     = cq.ycc ? MID_CODE : y_blank;

  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    logic chroma;
    assign chroma = (k != CH_G);
    vsb_chan_out #(.DW(DW), .LOW(LOW), .TOP_Y(TOP_Y), .TOP_C(TOP_C)) u_ch (
      .data      (data_q[k*DW +: DW]),
      .blank_code(chroma ? c_blank : y_blank),
      .hold      (blank_act),
      .scale_en  (chroma && scale_on),
      .code      (code_all[k*DW +: DW])
    );
    assign sync_en[k] = sync_act && (!chroma || cq.sync_all);
  end

  assign out_g    = code_all[CH_G*DW +: DW];
  assign out_b    = code_all[CH_B*DW +: DW];
  assign out_r    = code_all[CH_R*DW +: DW];
  assign sync_pos = sync_act && cq.sync_hi;
  assign bias_en  = video_mode;

  // Assertions
  a_r3_sync_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_n && !blank_n && !cfg_generic) |=> sync_en[0]);
  a_r3_sync_holds_blank: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_n && !cfg_generic && !cfg_reduced) |=> (out_g == '0));
  a_r5_chroma_mid: assert property (@(posedge clk) disable iff (!rst_n)
    (!blank_n && cfg_ycc) |=> (out_b == MID_CODE && out_r == MID_CODE));
  a_r6_pos_in_sync: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pos |-> sync_en[0]);
  a_r7_spread: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_en[1] || sync_en[2]) |-> (sync_en == 3'b111));
  a_r8_generic_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_generic |=> (sync_en == 3'b000 && !bias_en && !sync_pos));
  a_r8_generic_full_blank: assert property (@(posedge clk) disable iff (!rst_n)
    (!blank_n && cfg_generic) |=> (out_g == '0));
endmodule

// File: tb/vsb_top_test.sv
module vsb_top_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [9:0] in_g = 0, in_b = 0, in_r = 0;
  logic       blank_n = 1, sync_n = 1, sync_hi = 0;
  logic       cfg_ycc = 0, cfg_reduced = 0, cfg_sync_all = 0, cfg_generic = 0;
  logic [9:0] out_g, out_b, out_r;
  logic [2:0] sync_en;
  logic       sync_pos, bias_en;
  int         n_chk = 0, n_fail = 0;
  bit         done = 0;

  always #10 clk = ~clk;

  vsb_top uut (.*);

  // Bench model of the chroma rescale, using doubled integers
  function automatic int ref_scale(int c);
    int d2, q;
    d2 = (c - 512) * 876 * 2;
    if (d2 >= 0) q = (d2 + 896) / 1792;
    else         q = -((-d2 + 896) / 1792);
    q = 512 + q;
    if (q > 1023) q = 1023;
    if (q < 0) q = 0;
    return q;
  endfunction

  task automatic drive(input int g, b, r, input bit bl, sy, hi, ycc, red, all, gen);
    in_g = 10'(g); in_b = 10'(b); in_r = 10'(r);
    blank_n = bl; sync_n = sy; sync_hi = hi;
    cfg_ycc = ycc; cfg_reduced = red; cfg_sync_all = all; cfg_generic = gen;
  endtask

  task automatic check(input string tag);
    int eg, eb, er, yb, cb;
    bit reduced_eff, sync_on, hold;
    logic [2:0] es;
    bit ep, ebias;
    reduced_eff = cfg_reduced && !cfg_generic;
    sync_on = !sync_n && !cfg_generic;
    hold = sync_on || !blank_n;
    yb = reduced_eff ? 64 : 0;
    cb = cfg_ycc ? 512 : yb;
    if (hold) begin
      eg = yb; eb = cb; er = cb;
    end else if (reduced_eff && cfg_ycc) begin
      eg = in_g; eb = ref_scale(in_b); er = ref_scale(in_r);
    end else begin
      eg = in_g; eb = in_b; er = in_r;
    end
    es = sync_on ? (cfg_sync_all ? 3'b111 : 3'b001) : 3'b000;
    ep = sync_on && sync_hi;
    ebias = !cfg_generic;
    @(posedge clk); #5;
    n_chk++;
    if (out_g != 10'(eg) || out_b != 10'(eb) || out_r != 10'(er) ||
        sync_en != es || sync_pos != ep || bias_en != ebias) begin
      n_fail++;
      $display("FAIL %s: got g=%0d b=%0d r=%0d s=%b p=%b bias=%b exp g=%0d b=%0d r=%0d s=%b p=%b bias=%b",
               tag, out_g, out_b, out_r, sync_en, sync_pos, bias_en, eg, eb, er, es, ep, ebias);
    end
  endtask

  initial begin
    int seed;
    seed = 1234;
    void'($urandom(seed));
    #25;
    // R11 reset state
    n_chk++;
    if (out_g != 0 || out_b != 0 || out_r != 0 || sync_en != 0 || sync_pos != 0 || bias_en != 1) begin
      n_fail++;
      $display("FAIL R11: got g=%0d b=%0d r=%0d s=%b p=%b bias=%b exp 0 0 0 000 0 1",
               out_g, out_b, out_r, sync_en, sync_pos, bias_en);
    end
    @(negedge clk); rst_n = 1;
    // R1/R10 pass-through RGB full
    drive(100, 200, 300, 1, 1, 0, 0, 0, 0, 0); check("R1");
    drive(1023, 0, 555, 1, 1, 0, 0, 1, 0, 0); check("R10");
    // R2/R4 blanking RGB
    drive(900, 900, 900, 0, 1, 0, 0, 0, 0, 0); check("R4");
    drive(900, 900, 900, 0, 1, 0, 0, 1, 0, 0); check("R4");
    // R5 YCbCr blanking
    drive(700, 10, 20, 0, 1, 0, 1, 0, 0, 0); check("R5");
    drive(700, 10, 20, 0, 1, 0, 1, 1, 0, 0); check("R5");
    // R3 sync over blank, R6 polarity, R7 channel spread
    drive(500, 500, 500, 0, 0, 0, 1, 1, 0, 0); check("R3");
    drive(500, 500, 500, 1, 0, 1, 1, 1, 0, 0); check("R6");
    drive(333, 444, 555, 1, 0, 1, 0, 0, 1, 0); check("R7");
    drive(333, 444, 555, 0, 0, 0, 0, 1, 1, 0); check("R7");
    // R8 generic: sync ignored, full-range blanking, bias off
    drive(321, 654, 987, 1, 0, 1, 1, 1, 1, 1); check("R8");
    drive(321, 654, 987, 0, 0, 1, 0, 1, 1, 1); check("R8");
    drive(321, 654, 987, 1, 1, 0, 1, 1, 0, 1); check("R8");
    // R9 scaling corners: ties, span ends, code range ends
    drive(64, 624, 400, 1, 1, 0, 1, 1, 0, 0); check("R9");
    drive(940, 960, 64, 1, 1, 0, 1, 1, 0, 0); check("R9");
    drive(0, 0, 1023, 1, 1, 0, 1, 1, 0, 0); check("R9");
    drive(1023, 512, 511, 1, 1, 0, 1, 1, 0, 0); check("R9");
    // Random mix
    for (int i = 0; i < 3000; i++) begin
      bit bl, sy, gen, red, ycc;
      bl = ($urandom % 4) != 0; sy = ($urandom % 4) != 0;
      gen = ($urandom % 3) == 0; red = $urandom; ycc = $urandom;
      drive($urandom % 1024, $urandom % 1024, $urandom % 1024, bl, sy, $urandom, ycc, red,
            $urandom, gen);
      if (!sy && !gen)        check("R3");
      else if (!bl)           check("R2");
      else if (red && ycc && !gen) check("R9");
      else                    check("R10");
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule